// File: doc/BRIEF.md
# Memory Encryption Policy and Key-Select Unit

This unit stands between the memory request path and the cipher engine of a memory controller. Each read or write request carries a physical address, a requester kind (processor or DMA), an owner tag (tag 0 is the host, any other value is a guest), the guest's paging mode, and two flags that mark instruction fetches and page-table walks. From these and two global configuration levels the unit decides whether the data must pass through the cipher and which 128-bit key slot to use. It forwards the address with the encryption marker bit cleared, so the cipher can derive its address tweak from it, together with the selected key and an access-denied flag.

Key slots are loaded only through a dedicated load port: one slot per guest tag plus slot 0 for the host. No path lets a slot be read back by software. The key reaches the cipher only while the forwarded request is encrypted; otherwise the key output is zero. Decisions are registered with one cycle of latency, under valid/ready flow control on both the request and the output side.

Top module: `mcrypt_policy`

## Requirements
- R1: A request is accepted when `req_valid` and `req_ready` are both high, where `req_ready` is high exactly when the output stage is empty or `out_ready` is high. The decision appears on the outputs in the next cycle, with `out_addr` equal to `req_addr` with bit 47 cleared, and all outputs stay unchanged while `out_valid` is high and `out_ready` is low.
- R2: A host access is one with tag 0, or any access while guest keying is off (`cfg_guest_keys` low). Outside transparent mode it is encrypted with slot 0 exactly when address bit 47 is 1.
- R3: While `cfg_transparent` is high, every access that is not denied is encrypted with slot 0, and guest keying stays off even if `cfg_guest_keys` is high.
- R4: A processor access (`req_dma`=0) with a nonzero tag, guest keying on, paging mode 2 (32-bit PAE) or 3 (64-bit), neither fetch nor walk flag, is encrypted with slot equal to its tag when bit 47 is 1. When bit 47 is 0 it is shared and not encrypted.
- R5: A guest processor access in paging mode 0 (real) or 1 (32-bit without PAE) is treated as if bit 47 were 1, so it is encrypted with the guest's slot.
- R6: A guest processor access with `req_fetch` or `req_walk` high is encrypted with the guest's slot whatever bit 47 holds.
- R7: A DMA request with a nonzero tag, guest keying on and bit 47 set is denied. A DMA request ignores the fetch, walk and paging-mode inputs, and a host DMA with bit 47 set is encrypted with slot 0.
- R8: After reset every key slot is invalid until the load port writes it. An access that would be encrypted with an invalid slot is denied. A denied access has `out_encrypt`=0, `out_slot`=0 and `out_key`=0.
- R9: A key write takes place on a clock edge where `kl_valid` and `kl_ready` are both high. `kl_ready` is low while the output stage holds an encrypted request on `kl_slot`, or while a request being accepted would be encrypted with `kl_slot`. `out_key` equals the selected slot's key when `out_encrypt` is 1, and is 0 otherwise.
- R10: During and right after reset `out_valid` is 0, and `req_ready` and `kl_ready` are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_transparent | input | 1 | Encrypt every access with the host key |
| cfg_guest_keys | input | 1 | Enable per-guest key selection |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle when valid |
| req_addr | input | 48 | Physical address, bit 47 is the encryption marker |
| req_dma | input | 1 | Request comes from a DMA agent |
| req_tag | input | 3 | Owner tag, 0 = host |
| req_pmode | input | 2 | Guest paging mode: 0 real, 1 32-bit, 2 PAE, 3 64-bit |
| req_fetch | input | 1 | Instruction fetch |
| req_walk | input | 1 | Page-table walk |
| kl_valid | input | 1 | Key load request |
| kl_ready | output | 1 | Key load may complete this cycle |
| kl_slot | input | 3 | Slot to load |
| kl_key | input | 128 | Key value |
| out_valid | output | 1 | Decision present |
| out_ready | input | 1 | Downstream takes the decision |
| out_encrypt | output | 1 | Data path goes through the cipher |
| out_slot | output | 3 | Selected key slot |
| out_key | output | 128 | Key for the cipher, zero when not encrypting |
| out_addr | output | 48 | Address with the marker cleared (tweak input) |
| out_denied | output | 1 | Request refused, downstream drops it |

## Verification
The bench drives guest accesses whose marker is clear but which must still be private: low paging modes, fetches and walks. A design that trusted only bit 47 would send these unencrypted or with the host key. It sends guest DMA with the marker set, which must be refused rather than keyed with the guest slot, and accesses to unloaded slots, which must be denied rather than encrypted with a stale or zero key. It holds an encrypted request stalled while a load to the same slot is pending, so a design that overwrote the key under an in-flight request would show the new key early. It also checks that transparent mode overrides guest keying, which a design that let the guest path win would get wrong.

// File: rtl/mcrypt_pkg.sv
package mcrypt_pkg;

    // Guest paging mode encoding
    typedef enum logic [1:0] {
        PM_REAL = 2'd0,
        PM_PROT = 2'd1,
        PM_PAE  = 2'd2,
        PM_LONG = 2'd3
    } pmode_e;

    // Attributes of one request, apart from address and tag
    typedef struct packed {
        logic   dma;
        logic   fetch;
        logic   walk;
        pmode_e pmode;
    } req_attr_t;

    // Outcome flags of one decision
    typedef struct packed {
        logic enc;
        logic den;
    } verdict_t;

    // Paging modes in which the guest cannot drive the marker itself
    function automatic logic pm_forces_private(input pmode_e m);
        return (m == PM_REAL) || (m == PM_PROT);
    endfunction

endpackage

// File: rtl/mcrypt_decide.sv
module mcrypt_decide
    import mcrypt_pkg::*;
#(
    parameter int TAG_W = 3,
    localparam int NSLOT = 1 << TAG_W
) (
    input  logic             marker,
    input  logic [TAG_W-1:0] tag,
    input  req_attr_t        attr,
    input  logic             force_all,
    input  logic             guest_req,
    input  logic [NSLOT-1:0] slot_ok,
    output verdict_t         verdict,
    output logic [TAG_W-1:0] slot
);
    logic guest, cpu_priv, priv, want, dma_block, miss;
    logic [TAG_W-1:0] sel;

    always_comb begin
        // transparent mode shuts off per-guest keying
        guest     = guest_req && !force_all && (tag != '0);
        cpu_priv  = marker || attr.fetch || attr.walk || pm_forces_private(attr.pmode);
        priv      = guest && (attr.dma ? marker : cpu_priv);
        want      = force_all || priv || (!guest && marker);
        sel       = priv ? tag : '0;
        dma_block = guest && attr.dma && marker;
        miss      = want && !slot_ok[sel];
        verdict.den = dma_block || miss;
        verdict.enc = want && !verdict.den;
        slot        = verdict.den ? '0 : sel;
    end
endmodule

// File: rtl/mcrypt_keystore.sv
module mcrypt_keystore #(
    parameter int TAG_W = 3,
    parameter int KEY_W = 128,
    localparam int NSLOT = 1 << TAG_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [TAG_W-1:0] wr_slot,
    input  logic [KEY_W-1:0] wr_key,
    input  logic [TAG_W-1:0] rd_slot,
    output logic [KEY_W-1:0] rd_key,
    output logic [NSLOT-1:0] slot_ok
);
    logic [KEY_W-1:0] key_q [NSLOT];
    logic             ok_q  [NSLOT];

    for (genvar s = 0; s < NSLOT; s++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                key_q[s] <= '0;
                ok_q[s]  <= 1'b0;
            end else if (we && (wr_slot == TAG_W'(s))) begin
                key_q[s] <= wr_key;
                ok_q[s]  <= 1'b1;
            end
        end
        assign slot_ok[s] = ok_q[s];
    end

    // read port feeds only the cipher engine
    assign rd_key = key_q[rd_slot];
endmodule

// File: rtl/mcrypt_policy.sv
module mcrypt_policy
    import mcrypt_pkg::*;
#(
    parameter int ADDR_W   = 48,
    parameter int MARK_BIT = 47,
    parameter int TAG_W    = 3,
    parameter int KEY_W    = 128
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_transparent,
    input  logic              cfg_guest_keys,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_dma,
    input  logic [TAG_W-1:0]  req_tag,
    input  logic [1:0]        req_pmode,
    input  logic              req_fetch,
    input  logic              req_walk,
    input  logic              kl_valid,
    output logic              kl_ready,
    input  logic [TAG_W-1:0]  kl_slot,
    input  logic [KEY_W-1:0]  kl_key,
    output logic              out_valid,
    input  logic              out_ready,
    output logic              out_encrypt,
    output logic [TAG_W-1:0]  out_slot,
    output logic [KEY_W-1:0]  out_key,
    output logic [ADDR_W-1:0] out_addr,
    output logic              out_denied
);
    localparam int NSLOT = 1 << TAG_W;
    localparam logic [ADDR_W-1:0] MARK_MASK = ADDR_W'(1) << MARK_BIT;

    req_attr_t        attr;
    verdict_t         d_verdict, q_verdict;
    logic [TAG_W-1:0] d_slot, q_slot;
    logic [ADDR_W-1:0] q_addr;
    logic             q_valid, fire, key_we;
    logic [NSLOT-1:0] slot_ok;
    logic [KEY_W-1:0] rd_key;

    assign attr = '{dma: req_dma, fetch: req_fetch, walk: req_walk,
                    pmode: pmode_e'(req_pmode)};

    mcrypt_decide #(.TAG_W(TAG_W)) i_decide (
        .marker    (req_addr[MARK_BIT]),
        .tag       (req_tag),
        .attr      (attr),
        .force_all (cfg_transparent),
        .guest_req (cfg_guest_keys),
        .slot_ok   (slot_ok),
        .verdict   (d_verdict),
        .slot      (d_slot)
    );

    mcrypt_keystore #(.TAG_W(TAG_W), .KEY_W(KEY_W)) i_keys (
        .clk     (clk),
        .rst     (rst),
        .we      (key_we),
        .wr_slot (kl_slot),
        .wr_key  (kl_key),
        .rd_slot (q_slot),
        .rd_key  (rd_key),
        .slot_ok (slot_ok)
    );

    assign req_ready = !q_valid || out_ready;
    assign fire      = req_valid && req_ready;

    // a slot is busy while a held or an entering request is keyed by it
    assign kl_ready = !(q_valid && q_verdict.enc && (q_slot == kl_slot))
                   && !(fire && d_verdict.enc && (d_slot == kl_slot));
    assign key_we   = kl_valid && kl_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            q_valid   <= 1'b0;
            q_verdict <= '0;
            q_slot    <= '0;
            q_addr    <= '0;
        end else begin
            if (req_ready) q_valid <= req_valid;
            if (fire) begin
                q_verdict <= d_verdict;
                q_slot    <= d_slot;
                q_addr    <= req_addr & ~MARK_MASK;
            end
        end
    end

    assign out_valid   = q_valid;
    assign out_encrypt = q_verdict.enc;
    assign out_denied  = q_verdict.den;
    assign out_slot    = q_slot;
    assign out_addr    = q_addr;
    assign out_key     = q_verdict.enc ? rd_key : '0;
endmodule

// File: rtl/mcrypt_policy_chk.sv
module mcrypt_policy_chk #(
    parameter int ADDR_W   = 48,
    parameter int MARK_BIT = 47,
    parameter int TAG_W    = 3,
    parameter int KEY_W    = 128
) (
    input logic              clk,
    input logic              rst,
    input logic              cfg_transparent,
    input logic              req_valid,
    input logic              req_ready,
    input logic [TAG_W-1:0]  req_tag,
    input logic              req_dma,
    input logic              kl_valid,
    input logic              kl_ready,
    input logic [TAG_W-1:0]  kl_slot,
    input logic              out_valid,
    input logic              out_ready,
    input logic              out_encrypt,
    input logic [TAG_W-1:0]  out_slot,
    input logic [KEY_W-1:0]  out_key,
    input logic [ADDR_W-1:0] out_addr,
    input logic              out_denied
);
    // R1: a stalled decision does not move
    a_r1_hold: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> out_valid && $stable(out_addr)
            && $stable(out_slot) && $stable(out_encrypt) && $stable(out_denied));

    // R1: the marker never reaches the tweak address
    a_r1_marker_clear: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> !out_addr[MARK_BIT]);

    // R3: transparent mode only ever picks the host slot
    a_r3_host_slot: assert property (@(posedge clk) disable iff (rst)
        req_valid && req_ready && cfg_transparent |=> out_valid && out_slot == '0);

    // R2: host-tagged processor requests never use a guest slot
    a_r2_host_tag: assert property (@(posedge clk) disable iff (rst)
        req_valid && req_ready && req_tag == '0 |=> out_slot == '0);

    // R8: a refused request is never keyed
    a_r8_denied_plain: assert property (@(posedge clk) disable iff (rst)
        out_valid && out_denied |-> !out_encrypt && out_key == '0);

    // R9: no load lands on a slot held by an encrypted decision
    a_r9_no_overwrite: assert property (@(posedge clk) disable iff (rst)
        kl_valid && kl_ready |-> !(out_valid && out_encrypt && out_slot == kl_slot));

    // R9: a held encrypted decision keeps its key
    a_r9_key_stable: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready && out_encrypt |=> $stable(out_key));

    // R10: nothing comes out right after reset
    a_r10_empty: assert property (@(posedge clk)
        $past(rst) |-> !out_valid);
endmodule

bind mcrypt_policy mcrypt_policy_chk #(
    .ADDR_W(ADDR_W), .MARK_BIT(MARK_BIT), .TAG_W(TAG_W), .KEY_W(KEY_W)
) i_chk (.*);

// File: tb/test_mcrypt_policy.sv
module test_mcrypt_policy;
    localparam int CLK_PERIOD = 10;
    localparam logic [47:0] MARK = 48'h8000_0000_0000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cfg_transparent = 1'b0, cfg_guest_keys = 1'b1;
    logic req_valid = 1'b0, req_dma = 1'b0, req_fetch = 1'b0, req_walk = 1'b0;
    logic [47:0] req_addr = '0;
    logic [2:0]  req_tag = '0;
    logic [1:0]  req_pmode = 2'd3;
    logic kl_valid = 1'b0;
    logic [2:0] kl_slot = '0;
    logic [127:0] kl_key = '0;
    logic out_ready = 1'b1;
    logic req_ready, kl_ready, out_valid, out_encrypt, out_denied;
    logic [2:0] out_slot;
    logic [127:0] out_key;
    logic [47:0] out_addr;

    int n_cmp = 0, n_bad = 0;
    logic [127:0] sk [8];
    logic         sv [8];

    always #(CLK_PERIOD/2) clk = ~clk;

    mcrypt_policy i_mcrypt_policy (
        .clk(clk), .rst(rst),
        .cfg_transparent(cfg_transparent), .cfg_guest_keys(cfg_guest_keys),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_dma(req_dma), .req_tag(req_tag), .req_pmode(req_pmode),
        .req_fetch(req_fetch), .req_walk(req_walk),
        .kl_valid(kl_valid), .kl_ready(kl_ready), .kl_slot(kl_slot), .kl_key(kl_key),
        .out_valid(out_valid), .out_ready(out_ready), .out_encrypt(out_encrypt),
        .out_slot(out_slot), .out_key(out_key), .out_addr(out_addr),
        .out_denied(out_denied)
    );

    task automatic check(input string rq, input logic ok,
                         input logic [191:0] act, input logic [191:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    // expected decision from the requirements
    task automatic model(input logic mk, input logic dma, input logic [2:0] tag,
                         input logic [1:0] pm, input logic fe, input logic wk,
                         output logic enc, output logic den, output logic [2:0] slot);
        logic guest, want, priv;
        logic [2:0] s;
        guest = cfg_guest_keys && !cfg_transparent && tag != 0;
        den = 1'b0; priv = 1'b0; s = 3'd0;
        if (cfg_transparent) want = 1'b1;
        else if (!guest) want = mk;
        else if (dma) begin
            want = 1'b0;
            if (mk) den = 1'b1;
        end else begin
            priv = mk || fe || wk || pm < 2;
            want = priv;
            if (priv) s = tag;
        end
        if (want && !den && !sv[s]) den = 1'b1;
        enc  = want && !den;
        slot = den ? 3'd0 : s;
    endtask

    task automatic send(input string rq, input logic [47:0] a, input logic dma,
                        input logic [2:0] tag, input logic [1:0] pm,
                        input logic fe, input logic wk);
        logic e_enc, e_den;
        logic [2:0] e_slot;
        logic [127:0] e_key;
        @(negedge clk);
        req_addr = a; req_dma = dma; req_tag = tag; req_pmode = pm;
        req_fetch = fe; req_walk = wk; req_valid = 1'b1;
        model(a[47], dma, tag, pm, fe, wk, e_enc, e_den, e_slot);
        e_key = e_enc ? sk[e_slot] : '0;
        @(negedge clk);
        req_valid = 1'b0;
        check(rq, out_valid && out_encrypt == e_enc && out_denied == e_den
                  && out_slot == e_slot && out_addr == (a & ~MARK),
              {out_valid, out_encrypt, out_denied, out_slot, out_addr},
              {1'b1, e_enc, e_den, e_slot, a & ~MARK});
        check({rq, " key"}, out_key == e_key, out_key, e_key);
    endtask

    task automatic kload(input logic [2:0] s, input logic [127:0] k);
        @(negedge clk);
        kl_valid = 1'b1; kl_slot = s; kl_key = k;
        #1;
        while (!kl_ready) begin
            @(negedge clk);
            #1;
        end
        @(negedge clk);
        kl_valid = 1'b0;
        sk[s] = k; sv[s] = 1'b1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [127:0] newk;
        void'($urandom(32'h5eed_0042));
        for (int i = 0; i < 8; i++) begin sk[i] = '0; sv[i] = 1'b0; end
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R10 reset", !out_valid && req_ready && kl_ready,
              {out_valid, req_ready, kl_ready}, 3'b011);
        rst = 1'b0;
        @(negedge clk);
        check("R10 after reset", !out_valid && req_ready && kl_ready,
              {out_valid, req_ready, kl_ready}, 3'b011);

        // R8: host slot not loaded yet
        send("R8 host slot invalid", MARK | 48'h1000, 0, 0, 3, 0, 0);
        for (int s = 0; s < 4; s++)
            kload(3'(s), {$urandom, $urandom, $urandom, $urandom});

        send("R2 host marker", MARK | 48'h2040, 0, 0, 3, 0, 0);
        send("R2 host clear", 48'h0000_1234_5678, 0, 0, 3, 0, 0);
        send("R4 guest private", MARK | 48'h3000, 0, 2, 3, 0, 0);
        send("R4 guest shared", 48'h3000, 0, 2, 2, 0, 0);
        send("R5 real mode", 48'h4000, 0, 2, 0, 0, 0);
        send("R5 32-bit mode", 48'h4400, 0, 1, 1, 0, 0);
        send("R6 fetch", 48'h5000, 0, 3, 3, 1, 0);
        send("R6 walk", 48'h5800, 0, 3, 2, 0, 1);
        send("R7 guest dma private", MARK | 48'h6000, 1, 2, 3, 0, 0);
        send("R7 guest dma ignores attrs", 48'h6000, 1, 2, 0, 1, 1);
        send("R7 host dma", MARK | 48'h6100, 1, 0, 3, 0, 0);
        send("R8 guest slot invalid", MARK | 48'h7000, 0, 5, 3, 0, 0);
        cfg_guest_keys = 1'b0;
        send("R2 guest keying off", MARK | 48'h7100, 0, 2, 3, 1, 0);
        cfg_guest_keys = 1'b1; cfg_transparent = 1'b1;
        send("R3 transparent guest clear", 48'h7200, 0, 2, 3, 0, 0);
        send("R3 transparent dma", MARK | 48'h7300, 1, 5, 0, 0, 0);
        cfg_transparent = 1'b0;

        // R9 / R1: load blocked under a stalled encrypted decision
        @(negedge clk);
        out_ready = 1'b0;
        req_addr = MARK | 48'h8000; req_dma = 0; req_tag = 1; req_pmode = 3;
        req_fetch = 0; req_walk = 0; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0; req_addr = 48'h9999;
        newk = {$urandom, $urandom, $urandom, $urandom};
        kl_valid = 1'b1; kl_slot = 1; kl_key = newk;
        #1;
        check("R9 load blocked", !kl_ready, kl_ready, 1'b0);
        check("R1 stalled not ready", !req_ready, req_ready, 1'b0);
        kl_slot = 2;
        #1;
        check("R9 other slot free", kl_ready, kl_ready, 1'b1);
        kl_slot = 1;
        @(negedge clk);
        check("R1 held", out_valid && out_addr == 48'h8000 && out_slot == 1,
              {out_valid, out_slot, out_addr}, {1'b1, 3'd1, 48'h8000});
        check("R9 old key kept", out_key == sk[1], out_key, sk[1]);
        out_ready = 1'b1;
        @(negedge clk);
        check("R9 drained", !out_valid && kl_ready, {out_valid, kl_ready}, 2'b01);
        @(negedge clk);
        kl_valid = 1'b0;
        sk[1] = newk;
        send("R9 new key used", MARK | 48'h8100, 0, 1, 3, 0, 0);

        // random mix
        for (int i = 0; i < 400; i++) begin
            cfg_transparent = ($urandom % 6) == 0;
            cfg_guest_keys  = ($urandom % 4) != 0;
            if (i % 97 == 50)
                kload(3'($urandom % 4), {$urandom, $urandom, $urandom, $urandom});
            send("R4 random", {1'($urandom), 15'($urandom), $urandom},
                 1'(($urandom % 4) == 0), 3'($urandom), 2'($urandom),
                 1'(($urandom % 5) == 0), 1'(($urandom % 5) == 0));
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule